// File: doc/BRIEF.md
# Odd-Even Transposition Register Sorter

This block sorts a fixed-size batch of unsigned keys in ascending order. It keeps every key in a flat register array and runs a network of compare-swap cells, one cell for each neighbouring pair. On alternate cycles the cells serve the even pairing (0,1),(2,3),… or the odd pairing (1,2),(3,4),…. Each cycle is one phase, and a fixed count of phases equal to the number of keys is enough to leave any input sorted.

A batch is handled in three steps. A start pulse arms the loader. The keys then enter one per cycle through a serial port with a valid strobe. The sorter runs its phases on its own. It then drains the array through a serial output, smallest key first. Keys move through the same register chain for loading and for draining, so no wide multiplexer is needed to read the keys back. A one-cycle done pulse marks the end of a batch. The key width and the key count are parameters.

Top module: `ots_sorter`

## Requirements
- R1: After reset, out_valid and done are both low, and they stay low until a batch has been loaded and sorted.
- R2: After a start pulse accepted while idle, the block takes exactly NUM_KEYS keys, one on each rising edge at which in_valid is high. Cycles with in_valid low during loading are skipped and do not count.
- R3: The drained keys are the loaded keys in non-decreasing order, smallest first. Duplicates are all kept, and the extreme values 0 and 2^KEY_W-1 are handled.
- R4: Sorting lasts exactly NUM_KEYS cycles. out_valid is low for exactly NUM_KEYS cycles after the edge that takes the last key, and the first phase always uses the even pairing (pair 0,1).
- R5: out_valid is high for exactly NUM_KEYS consecutive cycles, with one key on out_key in each of those cycles.
- R6: done is high for exactly one cycle, the cycle right after the last out_valid cycle.
- R7: A start pulse has no effect while the block is loading, sorting or draining.
- R8: in_valid and in_key are ignored while the block is idle, sorting or draining. Keys offered then never appear at the output.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new batch when the block is idle |
| in_valid | input | 1 | in_key holds a key to load |
| in_key | input | KEY_W | Serial key input |
| out_valid | output | 1 | out_key holds a sorted key |
| out_key | output | KEY_W | Serial sorted key output |
| done | output | 1 | One-cycle pulse after the last key is drained |

## Verification
Some internal faults leave the output ordering and timing intact for the tested inputs. A corrupted phase counter or a wrong parity shows up as an out-of-order pair within the drained stream. It can also show up as a sort window of the wrong length, visible in the first cycle the drain would have started. A shift chain that moves on a stray in_valid or start replaces a drained key with a junk value, and the scoreboard flags it at that key's position. A controller that leaves its state early or late shows up one cycle late or early in the out_valid run length, or in where done falls.

// File: rtl/ots_pkg.sv
package ots_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_SORT  = 2'd2,
      ST_DRAIN = 2'd3
   } ots_state_e;
endpackage

// File: rtl/ots_cmp_swap.sv
module ots_cmp_swap #(
   parameter int KEY_W = 8
) (
   input  logic [KEY_W-1:0] a_lo,
   input  logic [KEY_W-1:0] a_hi,
   output logic [KEY_W-1:0] y_lo,
   output logic [KEY_W-1:0] y_hi
);
   // strict compare: equal keys stay in place
   logic swap;
   assign swap = a_lo > a_hi;
   assign y_lo = swap ? a_hi : a_lo;
   assign y_hi = swap ? a_lo : a_hi;
endmodule

// File: rtl/ots_ctrl.sv
module ots_ctrl
   import ots_pkg::*;
#(
   parameter int NUM_KEYS = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_valid,
   output logic shift_en,
   output logic sort_en,
   output logic parity,
   output logic out_valid,
   output logic done
);
   localparam int CNT_W = $clog2(NUM_KEYS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_KEYS - 1);

   ots_state_e       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         parity <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_LOAD;
                  cnt   <= '0;
               end
            end
            ST_LOAD: begin
               if (in_valid) begin
                  if (cnt == LAST) begin
                     state  <= ST_SORT;
                     cnt    <= '0;
                     parity <= 1'b0;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            ST_SORT: begin
               parity <= ~parity;
               if (cnt == LAST) begin
                  state <= ST_DRAIN;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            ST_DRAIN: begin
               if (cnt == LAST) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign shift_en  = ((state == ST_LOAD) && in_valid) || (state == ST_DRAIN);
   assign sort_en   = (state == ST_SORT);
   assign out_valid = (state == ST_DRAIN);

   // R4: first phase of every sort uses the even pairing
   a_r4_first_phase_even: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SORT && $past(state) == ST_LOAD) |-> !parity);
   // R4: pairings alternate on every phase
   a_r4_parity_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SORT && $past(state) == ST_SORT) |-> parity != $past(parity));
   // R6: done lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: done only follows the drain
   a_r6_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(state) == ST_DRAIN);
   // R7: start during sort never restarts loading
   a_r7_start_ignored_sort: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SORT && start) |=> state != ST_LOAD);
endmodule

// File: rtl/ots_array.sv
module ots_array #(
   parameter int KEY_W    = 8,
   parameter int NUM_KEYS = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             sort_en,
   input  logic             parity,
   input  logic [KEY_W-1:0] in_key,
   output logic [KEY_W-1:0] head_key
);
   localparam int EV_PAIRS = NUM_KEYS / 2;
   localparam int OD_PAIRS = (NUM_KEYS - 1) / 2;

   logic [KEY_W-1:0] arr    [NUM_KEYS];
   logic [KEY_W-1:0] ev_net [NUM_KEYS];
   logic [KEY_W-1:0] od_net [NUM_KEYS];

   // even pairing: (0,1),(2,3),...
   for (genvar p = 0; p < EV_PAIRS; p++) begin : g_even
      ots_cmp_swap #(.KEY_W(KEY_W)) u_cs (
         .a_lo(arr[2*p]), .a_hi(arr[2*p+1]),
         .y_lo(ev_net[2*p]), .y_hi(ev_net[2*p+1]));
   end
   if (NUM_KEYS % 2 == 1) begin : g_even_tail
      assign ev_net[NUM_KEYS-1] = arr[NUM_KEYS-1];
   end

   // odd pairing: (1,2),(3,4),...
   assign od_net[0] = arr[0];
   for (genvar p = 0; p < OD_PAIRS; p++) begin : g_odd
      ots_cmp_swap #(.KEY_W(KEY_W)) u_cs (
         .a_lo(arr[2*p+1]), .a_hi(arr[2*p+2]),
         .y_lo(od_net[2*p+1]), .y_hi(od_net[2*p+2]));
   end
   if (NUM_KEYS % 2 == 0) begin : g_odd_tail
      assign od_net[NUM_KEYS-1] = arr[NUM_KEYS-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_KEYS; i++) arr[i] <= '0;
      end else if (shift_en) begin
         for (int i = 0; i < NUM_KEYS - 1; i++) arr[i] <= arr[i+1];
         arr[NUM_KEYS-1] <= in_key;
      end else if (sort_en) begin
         for (int i = 0; i < NUM_KEYS; i++) arr[i] <= parity ? od_net[i] : ev_net[i];
      end
   end

   assign head_key = arr[0];
endmodule

// File: rtl/ots_sorter.sv
module ots_sorter #(
   parameter int KEY_W    = 8,
   parameter int NUM_KEYS = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             in_valid,
   input  logic [KEY_W-1:0] in_key,
   output logic             out_valid,
   output logic [KEY_W-1:0] out_key,
   output logic             done
);
   if (KEY_W < 1) begin : g_bad_width
      $error("ots_sorter: KEY_W must be at least 1");
   end
   if (NUM_KEYS < 2) begin : g_bad_count
      $error("ots_sorter: NUM_KEYS must be at least 2");
   end

   logic shift_en, sort_en, parity;

   ots_ctrl #(.NUM_KEYS(NUM_KEYS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .shift_en(shift_en), .sort_en(sort_en), .parity(parity),
      .out_valid(out_valid), .done(done));

   ots_array #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS)) u_array (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sort_en(sort_en),
      .parity(parity), .in_key(in_key), .head_key(out_key));

   // R3: drained stream never decreases
   a_r3_drain_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> $past(out_key) <= out_key);
   // R1: no output activity while reset is held
   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |=> !out_valid && !done);
endmodule

// File: tb/ots_sorter_test.sv
module ots_sorter_test;
   localparam int CLK_PERIOD = 10;
   localparam int KEY_W      = 8;
   localparam int NUM_KEYS   = 48;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             in_valid = 1'b0;
   logic [KEY_W-1:0] in_key = '0;
   logic             out_valid;
   logic [KEY_W-1:0] out_key;
   logic             done;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   int run_len = 0;
   bit prev_ov = 1'b0;
   bit prev_done = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ots_sorter #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_key(in_key), .out_valid(out_valid), .out_key(out_key), .done(done));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            run_len++;
            if (exp_q.size() == 0) check(1'b0, "R5 extra output", int'(out_key), -1);
            else begin
               int e;
               e = exp_q.pop_front();
               check(int'(out_key) == e, "R3 sorted key", int'(out_key), e);
            end
         end else if (prev_ov) begin
            check(run_len == NUM_KEYS, "R5 out_valid run length", run_len, NUM_KEYS);
            run_len = 0;
         end
         if (done) begin
            check(prev_ov && !out_valid, "R6 done right after last output", int'(prev_ov), 1);
            check(!prev_done, "R6 done single cycle", int'(prev_done), 0);
         end
         prev_ov   = out_valid;
         prev_done = done;
      end
   end

   function automatic int gen_key(input int mode, input int i);
      case (mode)
         0:       return ((NUM_KEYS - 1 - i) * 3) & 255;
         1:       return (i * 5) & 255;
         2:       return 8'h5A;
         3:       return ((i * 97 + 13) ^ (i * 29)) & 255;
         4:       return (i % 3) * 100;
         default: return (i % 2 == 1) ? 255 : 0;
      endcase
   endfunction

   task automatic run_set(input int mode, input bit gaps, input bit poke_sort, input bit poke_drain);
      int sq[$];
      int lows;
      int waitc;
      for (int i = 0; i < NUM_KEYS; i++) begin
         int k;
         int pos;
         k = gen_key(mode, i);
         pos = sq.size();
         for (int j = 0; j < sq.size(); j++) begin
            if (sq[j] > k) begin pos = j; break; end
         end
         sq.insert(pos, k);
      end
      foreach (sq[j]) exp_q.push_back(sq[j]);
      // R8: keys offered while idle are ignored
      in_valid = 1'b1; in_key = 8'hEE;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (gaps && (i % 5 == 2)) begin
            in_valid = 1'b0; in_key = 8'hEE; @(negedge clk);
         end
         in_valid = 1'b1; in_key = KEY_W'(gen_key(mode, i));
         start = (i == 10); // R7: start during load ignored
         @(negedge clk);
      end
      in_valid = 1'b0; start = 1'b0;
      lows = 0;
      while (!out_valid && lows < 4 * NUM_KEYS) begin
         lows++;
         if (poke_sort && lows == 3) begin
            start = 1'b1; in_valid = 1'b1; in_key = 8'h01; // R7, R8
         end else begin
            start = 1'b0; in_valid = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0; in_valid = 1'b0;
      check(lows == NUM_KEYS, "R4 sort phase count", lows, NUM_KEYS);
      waitc = 0;
      while (out_valid && waitc < 4 * NUM_KEYS) begin
         waitc++;
         if (poke_drain && waitc == 5) begin
            start = 1'b1; in_valid = 1'b1; in_key = 8'h00; // R7, R8
         end else begin
            start = 1'b0; in_valid = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0; in_valid = 1'b0;
      check(done == 1'b1, "R6 done after drain", int'(done), 1);
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2 all loaded keys emitted", exp_q.size(), 0);
      check(!out_valid, "R7 no extra batch started", int'(out_valid), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
      check(!done, "R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!out_valid, "R1 out_valid idle", int'(out_valid), 0);
      check(!done, "R1 done idle", int'(done), 0);
      run_set(0, 1'b0, 1'b0, 1'b0);
      run_set(1, 1'b1, 1'b0, 1'b0);
      run_set(2, 1'b0, 1'b1, 1'b0);
      run_set(3, 1'b1, 1'b1, 1'b1);
      run_set(4, 1'b0, 1'b0, 1'b1);
      run_set(5, 1'b1, 1'b1, 1'b1);
      run_set(0, 1'b0, 1'b1, 1'b1);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule